// File: doc/BRIEF.md
# Two-Channel Sample Mixer with Per-Channel Attenuation

This block merges two signed 16-bit sample streams into one output sample stream. Each channel is started and stopped on its own. Each channel is given a rate code and a volume code. The block divides the master clock (4.096 MHz in the target system) down to the sample rates. It asks each running channel for a sample at that channel's rate, scales the held sample by the channel's volume, adds the two results and clamps the sum to the 16-bit range. An output strobe comes with each mixed sample.

All sample rates come from one shared divider. The rate family of the channel that starts while the block is idle is locked in, and it stays in force as long as either channel runs. A channel that asks for a rate from another family is paced at the nearest rate of the locked family that is not slower than the one it asked for. When both channels are idle the lock is released.

Each input stream is valid/ready with no back-pressure toward the block. `ch_ready` is high for one cycle at each of the channel's sample instants. A sample is taken only in that cycle. If `ch_valid` is low then, the channel plays zero for that period. The output cannot be held back. `mix_valid` is a one-cycle strobe, and downstream logic must take `mix_data` in that cycle.

Top module: `pcm_duo_mixer`

## Requirements
- R1: A rate code is {family[3:2], octave[1:0]}. Family 0 (and code 3) has base divisor 1024, family 1 has 768 and family 2 has 640. A running channel's `ch_ready` period, in clock cycles, is the base divisor shifted right by the octave. Family 2 has no octave 3, and a request for it plays at octave 2.
- R2: The family of a channel that starts while both channels are idle becomes the locked family. If both channels start in the same cycle, channel 0 sets the lock. The lock holds while any channel runs. Once both channels are idle, the next start sets a new lock.
- R3: A channel that starts in a family other than the locked one gets the lowest rate of the locked family that is not below its requested rate. If no such rate exists, it gets the locked family's fastest rate.
- R4: For volume code v from 0 to 28, with e = v/4 and r = v%4, the channel's contribution is (sample*(8-r)) arithmetically shifted right by 3+e. Code 0 passes the sample unchanged.
- R5: Volume codes 29, 30 and 31 mute the channel, so its contribution is zero.
- R6: The two contributions are added at 17 bits. The sum clamps to 32767 and -32768 and never wraps.
- R7: A stopped or idle channel contributes zero. A start on a running channel is ignored, including any new rate code that comes with it. A start and a stop on an idle channel in the same cycle leave the channel idle.
- R8: `ch_ready` is high for exactly one cycle at each sample instant. A sample is captured only in that cycle. If `ch_valid` is low in that cycle, the channel holds zero for that period.
- R9: `mix_valid` pulses two cycles after each cycle in which any `ch_ready` is high, and at no other time. It stays low while both channels are idle.
- R10: During reset and after reset, `ch_ready`, `mix_valid` and `mix_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_start | input | 2 | Start pulse, one bit per channel |
| ch_stop | input | 2 | Stop pulse, one bit per channel |
| ch_rate | input | 8 | Rate code per channel, 4 bits each |
| ch_vol | input | 10 | Volume code per channel, 5 bits each |
| ch_valid | input | 2 | Sample valid per channel |
| ch_data | input | 32 | Signed sample per channel, 16 bits each |
| ch_ready | output | 2 | Sample accept window per channel |
| mix_data | output | 16 | Mixed, saturated sample |
| mix_valid | output | 1 | Mixed sample strobe |

## Verification
Every channel rate lands on one shared divider grid, so both channels often take a new sample in the same cycle. That same sum can then overflow, which means capture and saturation can coincide. The bench runs both channels at related octaves with constant full-scale samples of equal and of opposite sign, so that coincident captures feed straight into the clamp. A reference sum built from the samples seen at each ready cycle judges every strobe. A start request that arrives while the other channel is mid-stream lands on the same grid. That case is judged by measuring the interval between consecutive ready pulses against the mapped rate.

// File: rtl/pcm_mix_pkg.sv
package pcm_mix_pkg;

  localparam int RATE_W = 4;
  localparam int OCT_W  = 2;
  localparam int OCT_N  = 1 << OCT_W;

  typedef enum logic [1:0] {
    FAM_4K  = 2'd0,
    FAM_5K3 = 2'd1,
    FAM_6K4 = 2'd2
  } fam_e;

  function automatic fam_e fam_of(input logic [RATE_W-1:0] code);
    case (code[RATE_W-1:OCT_W])
      2'd1:    return FAM_5K3;
      2'd2:    return FAM_6K4;
      default: return FAM_4K;
    endcase
  endfunction

  // prescale factor: base divisor = pre * 2^(SUB_W)
  function automatic logic [3:0] pre_of(input fam_e f);
    case (f)
      FAM_5K3: return 4'd6;
      FAM_6K4: return 4'd5;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [OCT_W-1:0] top_oct(input fam_e f);
    return (f == FAM_6K4) ? OCT_W'(2) : OCT_W'(3);
  endfunction

  function automatic logic [OCT_W-1:0] oct_of(input logic [RATE_W-1:0] code);
    logic [OCT_W-1:0] o;
    o = code[OCT_W-1:0];
    if (o > top_oct(fam_of(code))) o = top_oct(fam_of(code));
    return o;
  endfunction

  // slowest octave of lf whose period does not exceed the requested one
  function automatic logic [OCT_W-1:0] map_oct(input fam_e rf,
                                               input logic [OCT_W-1:0] ro,
                                               input fam_e lf);
    logic [7:0]       want;
    logic [7:0]       have;
    logic [OCT_W-1:0] pick;
    logic             hit;
    want = 8'(pre_of(rf)) << (OCT_N - 1 - int'(ro));
    pick = top_oct(lf);
    hit  = 1'b0;
    for (int o = 0; o < OCT_N; o++) begin
      have = 8'(pre_of(lf)) << (OCT_N - 1 - o);
      if (!hit && o <= int'(top_oct(lf)) && have <= want) begin
        pick = OCT_W'(o);
        hit  = 1'b1;
      end
    end
    return pick;
  endfunction

  function automatic logic [OCT_W-1:0] place_oct(input logic [RATE_W-1:0] code,
                                                 input fam_e lf);
    if (fam_of(code) == lf) return oct_of(code);
    return map_oct(fam_of(code), oct_of(code), lf);
  endfunction

endpackage

// File: rtl/pcm_rate_lock.sv
module pcm_rate_lock
  import pcm_mix_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        start_req,
  input  logic [NCH-1:0]        stop_req,
  input  logic [NCH*RATE_W-1:0] rate_code,
  output logic [NCH-1:0]        run,
  output fam_e                  lock_fam,
  output logic [NCH*OCT_W-1:0]  eff_oct,
  output logic [NCH-1:0]        launch
);

  logic any_run;
  fam_e lead_fam;

  assign any_run = |run;
  assign launch  = start_req & ~stop_req & ~run;

  // lowest-numbered launching channel picks the family when idle
  always_comb begin
    lead_fam = lock_fam;
    if (!any_run) begin
      for (int k = NCH - 1; k >= 0; k--) begin
        if (launch[k]) lead_fam = fam_of(rate_code[k*RATE_W +: RATE_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_fam <= FAM_4K;
    else        lock_fam <= lead_fam;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic             run_q;
    logic [OCT_W-1:0] oct_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= 1'b0;
        oct_q <= '0;
      end else if (stop_req[g]) begin
        run_q <= 1'b0;
      end else if (launch[g]) begin
        run_q <= 1'b1;
        oct_q <= place_oct(rate_code[g*RATE_W +: RATE_W], lead_fam);
      end
    end

    assign run[g]                      = run_q;
    assign eff_oct[g*OCT_W +: OCT_W]   = oct_q;
  end

endmodule

// File: rtl/pcm_rate_strobe.sv
module pcm_rate_strobe
  import pcm_mix_pkg::*;
#(
  parameter int SUB_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_any,
  input  fam_e             fam,
  output logic [OCT_N-1:0] tick
);

  localparam int PRE_W = 4;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_max;
  logic [SUB_W-1:0] sub_cnt;
  logic             wrap;

  assign pre_max = pre_of(fam) - PRE_W'(1);
  assign wrap    = run_any && (pre_cnt == pre_max);

  always_ff @(posedge clk) begin
    if (!rst_n || !run_any) begin
      pre_cnt <= '0;
      sub_cnt <= '0;
    end else begin
      pre_cnt <= wrap ? '0 : pre_cnt + PRE_W'(1);
      if (wrap) sub_cnt <= sub_cnt + SUB_W'(1);
    end
  end

  // octave o fires every pre * 2^(SUB_W-o) cycles
  for (genvar o = 0; o < OCT_N; o++) begin : g_oct
    assign tick[o] = wrap && (&sub_cnt[SUB_W-1-o:0]);
  end

endmodule

// File: rtl/pcm_mix_lane.sv
module pcm_mix_lane #(
  parameter int DATA_W    = 16,
  parameter int VOL_W     = 5,
  parameter int MUTE_FROM = 29
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     launch,
  input  logic                     tick,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic [VOL_W-1:0]         vol,
  output logic                     in_ready,
  output logic signed [DATA_W-1:0] scaled
);

  localparam int PROD_W = DATA_W + 5;
  localparam int EXP_W  = VOL_W - 2;

  logic signed [DATA_W-1:0] hold;
  logic [3:0]               gain_num;
  logic [EXP_W-1:0]         vexp;
  logic [VOL_W-1:0]         shamt;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic                     muted;

  assign in_ready = run & tick;

  always_ff @(posedge clk) begin
    if (!rst_n || launch) hold <= '0;
    else if (in_ready)    hold <= in_valid ? in_data : '0;
  end

  assign vexp     = vol[VOL_W-1:2];
  assign gain_num = 4'd8 - {2'b00, vol[1:0]};
  assign shamt    = VOL_W'(3) + VOL_W'(vexp);
  assign muted    = (vol >= VOL_W'(MUTE_FROM));
  assign prod     = PROD_W'(hold) * PROD_W'($signed({1'b0, gain_num}));
  assign shifted  = prod >>> shamt;
  assign scaled   = (run && !muted) ? shifted[DATA_W-1:0] : '0;

endmodule

// File: rtl/pcm_mix_sat.sv
module pcm_mix_sat #(
  parameter int NCH    = 2,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [NCH*DATA_W-1:0]   parts,
  output logic [DATA_W-1:0]       mix_data,
  output logic                    mix_valid
);

  localparam int SUM_W = DATA_W + $clog2(NCH);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = ~HI;

  logic signed [SUM_W-1:0]  sum;
  logic signed [DATA_W-1:0] clamped;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NCH; k++) begin
      sum = sum + SUM_W'($signed(parts[k*DATA_W +: DATA_W]));
    end
    if (sum > HI)      clamped = HI[DATA_W-1:0];
    else if (sum < LO) clamped = LO[DATA_W-1:0];
    else               clamped = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mix_data  <= '0;
      mix_valid <= 1'b0;
    end else begin
      mix_valid <= go;
      if (go) mix_data <= clamped;
    end
  end

endmodule

// File: rtl/pcm_duo_mixer.sv
module pcm_duo_mixer
  import pcm_mix_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int DATA_W    = 16,
  parameter int VOL_W     = 5,
  parameter int SUB_W     = 7,
  parameter int MUTE_FROM = 29
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          ch_start,
  input  logic [NCH-1:0]          ch_stop,
  input  logic [NCH*RATE_W-1:0]   ch_rate,
  input  logic [NCH*VOL_W-1:0]    ch_vol,
  input  logic [NCH-1:0]          ch_valid,
  input  logic [NCH*DATA_W-1:0]   ch_data,
  output logic [NCH-1:0]          ch_ready,
  output logic [DATA_W-1:0]       mix_data,
  output logic                    mix_valid
);

  logic [NCH-1:0]        run_w;
  logic [NCH-1:0]        launch_w;
  logic [NCH*OCT_W-1:0]  eff_w;
  fam_e                  lock_fam_w;
  logic [OCT_N-1:0]      tick_oct;
  logic [NCH-1:0]        lane_tick;
  logic [NCH*DATA_W-1:0] scaled_w;
  logic                  mix_go;

  pcm_rate_lock #(.NCH(NCH)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (ch_start),
    .stop_req  (ch_stop),
    .rate_code (ch_rate),
    .run       (run_w),
    .lock_fam  (lock_fam_w),
    .eff_oct   (eff_w),
    .launch    (launch_w)
  );

  pcm_rate_strobe #(.SUB_W(SUB_W)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_any (|run_w),
    .fam     (lock_fam_w),
    .tick    (tick_oct)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane_tick[g] = tick_oct[eff_w[g*OCT_W +: OCT_W]];

    pcm_mix_lane #(
      .DATA_W    (DATA_W),
      .VOL_W     (VOL_W),
      .MUTE_FROM (MUTE_FROM)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_w[g]),
      .launch   (launch_w[g]),
      .tick     (lane_tick[g]),
      .in_valid (ch_valid[g]),
      .in_data  (ch_data[g*DATA_W +: DATA_W]),
      .vol      (ch_vol[g*VOL_W +: VOL_W]),
      .in_ready (ch_ready[g]),
      .scaled   (scaled_w[g*DATA_W +: DATA_W])
    );
  end

  // captured samples settle one cycle before they are summed
  always_ff @(posedge clk) begin
    if (!rst_n) mix_go <= 1'b0;
    else        mix_go <= |ch_ready;
  end

  pcm_mix_sat #(.NCH(NCH), .DATA_W(DATA_W)) u_sat (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (mix_go),
    .parts     (scaled_w),
    .mix_data  (mix_data),
    .mix_valid (mix_valid)
  );

endmodule

// File: rtl/pcm_duo_mixer_chk.sv
module pcm_duo_mixer_chk #(
  parameter int NCH       = 2,
  parameter int DATA_W    = 16,
  parameter int VOL_W     = 5,
  parameter int MUTE_FROM = 29
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0]        ch_ready,
  input logic [NCH*VOL_W-1:0]  ch_vol,
  input logic [DATA_W-1:0]     mix_data,
  input logic                  mix_valid,
  input logic [NCH-1:0]        run,
  input logic [1:0]            lock_fam,
  input logic [NCH*DATA_W-1:0] scaled
);

  logic [NCH-1:0] neg;
  logic [NCH-1:0] muted;

  for (genvar k = 0; k < NCH; k++) begin : g_sig
    assign neg[k]   = scaled[k*DATA_W + DATA_W - 1];
    assign muted[k] = ch_vol[k*VOL_W +: VOL_W] >= VOL_W'(MUTE_FROM);

    assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_ready[k] |=> !ch_ready[k]);
  end

  assert_lock_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|run) && $past(|run)) |-> $stable(lock_fam));

  assert_strobe_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mix_valid |-> $past(|ch_ready, 2));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_valid && $past(neg == '0)) |-> !mix_data[DATA_W-1]);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_valid && $past(&neg)) |-> mix_data[DATA_W-1]);

  assert_mute_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_valid && $past(&muted)) |-> (mix_data == '0));

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_valid && $past(run == '0)) |-> (mix_data == '0));

endmodule

bind pcm_duo_mixer pcm_duo_mixer_chk #(
  .NCH       (NCH),
  .DATA_W    (DATA_W),
  .VOL_W     (VOL_W),
  .MUTE_FROM (MUTE_FROM)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_ready  (ch_ready),
  .ch_vol    (ch_vol),
  .mix_data  (mix_data),
  .mix_valid (mix_valid),
  .run       (run_w),
  .lock_fam  (lock_fam_w),
  .scaled    (scaled_w)
);

// File: tb/pcm_duo_mixer_tb.sv
module pcm_duo_mixer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ch_start = '0;
  logic [1:0]  ch_stop = '0;
  logic [7:0]  ch_rate = '0;
  logic [9:0]  ch_vol = '0;
  logic [1:0]  ch_valid = 2'b11;
  logic [31:0] ch_data = '0;
  logic [1:0]  ch_ready;
  logic [15:0] mix_data;
  logic        mix_valid;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;
  int     exp_per [2];
  longint last_rdy [2];
  int     hold_e [2];
  bit     run_e [2];
  int     rdy_cnt [2];
  int     mix_cnt = 0;
  string  per_tag [2];
  string  mix_tag = "R4";
  bit     const_mode [2];
  int     const_val [2];

  always #2 clk = ~clk;

  pcm_duo_mixer u_dut (
    .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .ch_stop(ch_stop),
    .ch_rate(ch_rate), .ch_vol(ch_vol), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_ready(ch_ready), .mix_data(mix_data), .mix_valid(mix_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int scale_ref(input int s, input int v);
    int p;
    if (v >= 29) return 0;
    p = s * (8 - (v % 4));
    return p >>> (3 + v / 4);
  endfunction

  function automatic int mix_ref();
    int s = 0;
    for (int k = 0; k < 2; k++)
      if (run_e[k]) s += scale_ref(hold_e[k], int'(ch_vol[k*5 +: 5]));
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic int fam_ref(input int code);
    return ((code >> 2) == 3) ? 0 : (code >> 2);
  endfunction

  function automatic int base_ref(input int fam);
    return (fam == 0) ? 1024 : (fam == 1) ? 768 : 640;
  endfunction

  function automatic int top_ref(input int fam);
    return (fam == 2) ? 2 : 3;
  endfunction

  // period in clocks for a channel requesting code under lock family lf
  function automatic int per_ref(input int code, input int lf);
    int f = fam_ref(code);
    int o = code & 3;
    int want;
    if (o > top_ref(f)) o = top_ref(f);
    want = base_ref(f) >> o;
    if (f == lf) return want;
    for (int q = 0; q <= top_ref(lf); q++)
      if ((base_ref(lf) >> q) <= want) return base_ref(lf) >> q;
    return base_ref(lf) >> top_ref(lf);
  endfunction

  // sample driver: new data each cycle, a little after the edge
  initial forever begin
    @(posedge clk);
    #1;
    for (int k = 0; k < 2; k++)
      ch_data[k*16 +: 16] = const_mode[k] ? 16'(const_val[k]) : 16'($urandom);
  end

  // monitor at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      if (mix_valid) begin
        mix_cnt++;
        chk(mix_tag, int'($signed(mix_data)), mix_ref());
      end
      for (int k = 0; k < 2; k++) begin
        if (ch_ready[k]) begin
          rdy_cnt[k]++;
          if (exp_per[k] != 0 && last_rdy[k] >= 0)
            chk(per_tag[k], int'(cyc - last_rdy[k]), exp_per[k]);
          last_rdy[k] = cyc;
          hold_e[k] = ch_valid[k] ? int'($signed(ch_data[k*16 +: 16])) : 0;
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic start_ch(input bit [1:0] mask);
    step();
    ch_start = mask;
    for (int k = 0; k < 2; k++)
      if (mask[k] && !run_e[k]) begin
        run_e[k] = 1'b1;
        hold_e[k] = 0;
        last_rdy[k] = -1;
      end
    step();
    ch_start = '0;
  endtask

  task automatic stop_ch(input bit [1:0] mask);
    step();
    ch_stop = mask;
    for (int k = 0; k < 2; k++)
      if (mask[k]) begin
        run_e[k] = 1'b0;
        exp_per[k] = 0;
      end
    step();
    ch_stop = '0;
  endtask

  task automatic wait_out(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!mix_valid) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c0;
    int m0;
    void'($urandom(32'd4242));
    for (int k = 0; k < 2; k++) begin
      exp_per[k] = 0; last_rdy[k] = -1; hold_e[k] = 0; run_e[k] = 0;
      rdy_cnt[k] = 0; per_tag[k] = "R1"; const_mode[k] = 0; const_val[k] = 0;
    end

    // R10: reset state
    repeat (4) @(negedge clk);
    chk("R10", int'(ch_ready), 0);
    chk("R10", int'(mix_valid), 0);
    chk("R10", int'(mix_data), 0);
    step();
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk("R9", mix_cnt, 0);

    // R1 R4: channel 0 alone, 32 kHz-class code, full level
    ch_rate[3:0] = 4'b0011; ch_vol[4:0] = 5'd0;
    start_ch(2'b01);
    exp_per[0] = 128; per_tag[0] = "R1";
    wait_out(5);

    // R3: channel 1 asks family 2 octave 2 during family 0 playback -> 128
    ch_rate[7:4] = 4'b1010; ch_vol[9:5] = 5'd5;
    start_ch(2'b10);
    exp_per[1] = per_ref(4'b1010, 0); per_tag[1] = "R3";
    chk("R3", exp_per[1], 128);
    wait_out(5);

    // R7: restart of a running channel with a new code is ignored
    ch_rate[7:4] = 4'b0100; per_tag[1] = "R7";
    start_ch(2'b10);
    wait_out(4);

    // R2: lock held after the first channel ends
    stop_ch(2'b01);
    per_tag[1] = "R2";
    wait_out(4);
    stop_ch(2'b10);
    m0 = mix_cnt;
    repeat (400) @(negedge clk);
    chk("R9", mix_cnt - m0, 0);

    // R2: new lock after idle; R3 mapping into family 2
    ch_rate[7:4] = 4'b1010; ch_vol[9:5] = 5'd0;
    start_ch(2'b10);
    exp_per[1] = 160; per_tag[1] = "R2";
    wait_out(3);
    ch_rate[3:0] = 4'b0001; ch_vol[4:0] = 5'd9;
    start_ch(2'b01);
    exp_per[0] = per_ref(4'b0001, 2); per_tag[0] = "R3";
    chk("R3", exp_per[0], 320);
    wait_out(6);
    stop_ch(2'b11);

    // R2: simultaneous start, channel 0 family wins (family 1)
    ch_rate = {4'b0011, 4'b0111};
    start_ch(2'b11);
    exp_per[0] = 96; exp_per[1] = per_ref(4'b0011, 1);
    per_tag[0] = "R2"; per_tag[1] = "R2";
    chk("R2", exp_per[1], 96);
    wait_out(5);
    stop_ch(2'b11);

    // R3: no rate fast enough in the locked family -> its fastest rate
    ch_rate = {4'b0111, 4'b0010};
    start_ch(2'b01);
    exp_per[0] = 256; per_tag[0] = "R1";
    wait_out(2);
    start_ch(2'b10);
    exp_per[1] = per_ref(4'b0111, 0); per_tag[1] = "R3";
    chk("R3", exp_per[1], 128);
    wait_out(6);

    // R6: saturation with coincident captures
    mix_tag = "R6";
    ch_vol = '0;
    const_mode[0] = 1; const_mode[1] = 1;
    const_val[0] = 32767; const_val[1] = 32767;
    wait_out(4);
    const_val[0] = -32768; const_val[1] = -32768;
    wait_out(4);
    const_val[0] = 32767; const_val[1] = -32768;
    wait_out(3);
    const_mode[0] = 0; const_mode[1] = 0;

    // R5: mute codes
    mix_tag = "R5";
    ch_vol[9:5] = 5'd29; wait_out(3);
    ch_vol[9:5] = 5'd30; wait_out(3);
    ch_vol[9:5] = 5'd31; ch_vol[4:0] = 5'd31; wait_out(3);
    ch_vol = '0;

    // R8: underrun on channel 1 plays zero
    mix_tag = "R8";
    ch_valid[1] = 1'b0; wait_out(4);
    ch_valid[1] = 1'b1; wait_out(3);

    // R7: stopped channel contributes zero; start+stop on idle stays idle
    mix_tag = "R7";
    stop_ch(2'b10);
    wait_out(3);
    c0 = rdy_cnt[1];
    step();
    ch_start = 2'b10; ch_stop = 2'b10;
    step();
    ch_start = '0; ch_stop = '0;
    wait_out(4);
    chk("R7", rdy_cnt[1] - c0, 0);
    stop_ch(2'b01);

    // R4 R1 R3: random rounds with random volumes and families
    mix_tag = "R4";
    for (int r = 0; r < 12; r++) begin
      int f0 = $urandom_range(0, 2);
      int f1 = $urandom_range(0, 2);
      int c0r = (f0 << 2) | $urandom_range(2, 3);
      int c1r = (f1 << 2) | $urandom_range(2, 3);
      ch_rate = {4'(c1r), 4'(c0r)};
      ch_vol = {5'($urandom_range(0, 31)), 5'($urandom_range(0, 31))};
      start_ch(2'b11);
      exp_per[0] = per_ref(c0r, fam_ref(c0r));
      exp_per[1] = per_ref(c1r, fam_ref(c0r));
      per_tag[0] = "R1"; per_tag[1] = "R3";
      wait_out(8);
      stop_ch(2'b11);
      repeat (20) @(negedge clk);
    end

    finish_run();
  end

endmodule